// File: doc/BRIEF.md
# Execute Register Bank and Arithmetic Unit

This block is the execute stage of a small 16-bit processor. It owns eight 16-bit registers and a single-cycle arithmetic and logic unit with eight operations. A decoder outside the block presents already-separated fields: an operation code, a destination index, a left source index, and either a right source index or a 16-bit immediate. One operation is accepted per clock. Its result is written back on the same clock edge, and the zero and carry flags are updated on that edge too.

Two register slots are fixed constants. Index 0 always reads zero and index 7 always reads all ones. Any write aimed at either slot is dropped without notice, but the flags still follow the computed result. A neighbouring control unit reads the flags, a one-cycle illegal-operation pulse, and two extra read ports that look straight into the register bank.

Operations arrive on a valid/ready stream. `in_ready` is high in every cycle outside reset, so the only back-pressure is reset itself. An operation is taken on a rising edge where both `in_valid` and `in_ready` are high. A cycle where `in_valid` is low changes nothing.

Top module: `exec_regfile_alu`

## Requirements
- R1: Registers 1 to 6 reset to 0x0000. An accepted legal operation writes its result into the destination register on the accepting edge. The read ports are combinational, so the new value appears on them in the next cycle.
- R2: Register 0 reads 0x0000 on every port at all times.
- R3: Register 7 reads 0xFFFF on every port from reset onward.
- R4: An accepted legal operation whose destination is 0 or 7 leaves that register unchanged, but it still updates the zero flag (and the carry flag where R9 applies) from the computed result.
- R5: The operation codes are 0 add, 1 subtract, 2 shift left, 3 shift right, 4 AND, 5 OR, 6 XOR and 7 multiply. Multiply keeps the low 16 bits of the product.
- R6: After an accepted legal operation, `flag_zero` is 1 exactly when the 16-bit result is 0x0000.
- R7: When `in_use_imm` is 1, `in_imm` replaces the right source register as the right operand, and the operation semantics are identical.
- R8: Shift right fills with zeros. Add, subtract and multiply wrap modulo 2^16.
- R9: `flag_carry` takes the carry out of bit 15 on add and the borrow (left operand less than right operand) on subtract. It keeps its value on every other operation.
- R10: A shift by a right operand of 16 or more gives 0x0000.
- R11: An accepted operation code of 8 to 15 raises `op_error` for exactly the following cycle and changes neither the registers nor the flags.
- R12: `in_ready` is low during reset and high otherwise. A cycle without an accepted operation changes no register, no flag, and leaves `op_error` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation fields are valid |
| in_ready | output | 1 | Block accepts an operation (high outside reset) |
| in_op | input | 4 | Operation code |
| in_use_imm | input | 1 | Use the immediate as the right operand |
| in_dst | input | 3 | Destination register index |
| in_src_a | input | 3 | Left source register index |
| in_src_b | input | 3 | Right source register index |
| in_imm | input | 16 | Immediate right operand |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry / borrow flag |
| op_error | output | 1 | One-cycle pulse after an illegal operation code |
| rd0_addr | input | 3 | Index for external read port 0 |
| rd0_data | output | 16 | Data of external read port 0 |
| rd1_addr | input | 3 | Index for external read port 1 |
| rd1_data | output | 16 | Data of external read port 1 |

## Verification
The bench builds the block with its default parameters: a 16-bit datapath, eight registers and a 4-bit operation code. With these values every register index can be driven, including both constant slots. Shift amounts of 15, 16 and beyond can be reached from both a register and an immediate. Half of the operation-code space is illegal, so a mixed random stream hits the error path often. The full operand width also lets the bench force carry out of bit 15, borrow, and multiply wrap with chosen operands.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_SHL = 4'd2,
    OP_SHR = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_MUL = 4'd7
  } alu_op_e;

  localparam int unsigned LEGAL_OPS = 8;

endpackage

// File: rtl/exec_regbank.sv
module exec_regbank #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned REG_CNT  = 8,
  parameter int unsigned RD_PORTS = 4,
  localparam int unsigned AW = $clog2(REG_CNT)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [RD_PORTS-1:0][AW-1:0]      rd_addr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data
);

  localparam int unsigned LOW_CONST  = 0;
  localparam int unsigned HIGH_CONST = REG_CNT - 1;

  logic [DATA_W-1:0] regs_q [REG_CNT];

  // Constant slots are wired; the general ones are flops with their own enable.
  for (genvar g = 0; g < REG_CNT; g++) begin : g_slot
    if (g == LOW_CONST) begin : g_zero
      assign regs_q[g] = '0;
    end else if (g == HIGH_CONST) begin : g_ones
      assign regs_q[g] = '1;
    end else begin : g_gen
      logic hit;
      assign hit = wr_en && (wr_addr == AW'(g));
      always_ff @(posedge clk) begin
        if (rst) begin
          regs_q[g] <= '0;
        end else if (hit) begin
          regs_q[g] <= wr_data;
        end
      end
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_data[p] = regs_q[rd_addr[p]];
  end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              carry_upd,
  output logic              legal
);

  localparam int unsigned SHW = $clog2(DATA_W);

  logic [DATA_W:0]     sum_ext;
  logic [DATA_W:0]     dif_ext;
  logic [2*DATA_W-1:0] prod;
  logic                shift_big;

  assign sum_ext   = {1'b0, lhs} + {1'b0, rhs};
  assign dif_ext   = {1'b0, lhs} - {1'b0, rhs};
  assign prod      = lhs * rhs;
  assign shift_big = |rhs[DATA_W-1:SHW];

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    carry_upd = 1'b0;
    legal     = 1'b1;
    unique case (op)
      OP_ADD: begin
        result    = sum_ext[DATA_W-1:0];
        carry_out = sum_ext[DATA_W];
        carry_upd = 1'b1;
      end
      OP_SUB: begin
        result    = dif_ext[DATA_W-1:0];
        carry_out = dif_ext[DATA_W];
        carry_upd = 1'b1;
      end
      OP_SHL: result = shift_big ? '0 : (lhs << rhs[SHW-1:0]);
      OP_SHR: result = shift_big ? '0 : (lhs >> rhs[SHW-1:0]);
      OP_AND: result = lhs & rhs;
      OP_OR:  result = lhs | rhs;
      OP_XOR: result = lhs ^ rhs;
      OP_MUL: result = prod[DATA_W-1:0];
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/exec_flags.sv
module exec_flags #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              legal,
  input  logic [DATA_W-1:0] result,
  input  logic              carry_upd,
  input  logic              carry_in,
  output logic              zero_q,
  output logic              carry_q,
  output logic              err_q
);

  logic commit;
  assign commit = take && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= take && !legal;
      if (commit) begin
        zero_q <= (result == '0);
        if (carry_upd) begin
          carry_q <= carry_in;
        end
      end
    end
  end

endmodule

// File: rtl/exec_regfile_alu.sv
module exec_regfile_alu
  import exec_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned REG_CNT = 8,
  localparam int unsigned AW = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_use_imm,
  input  logic [AW-1:0]     in_dst,
  input  logic [AW-1:0]     in_src_a,
  input  logic [AW-1:0]     in_src_b,
  input  logic [DATA_W-1:0] in_imm,
  output logic              flag_zero,
  output logic              flag_carry,
  output logic              op_error,
  input  logic [AW-1:0]     rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [AW-1:0]     rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);

  localparam int unsigned RD_PORTS = 4;
  localparam int unsigned P_LHS = 0;
  localparam int unsigned P_RHS = 1;
  localparam int unsigned P_EX0 = 2;
  localparam int unsigned P_EX1 = 3;

  logic                            take;
  logic [RD_PORTS-1:0][AW-1:0]     rd_addr;
  logic [RD_PORTS-1:0][DATA_W-1:0] rd_data;
  logic [DATA_W-1:0]               rhs;
  logic [DATA_W-1:0]               result;
  logic                            carry_out;
  logic                            carry_upd;
  logic                            legal;

  assign in_ready = !rst;
  assign take     = in_valid && in_ready;

  assign rd_addr[P_LHS] = in_src_a;
  assign rd_addr[P_RHS] = in_src_b;
  assign rd_addr[P_EX0] = rd0_addr;
  assign rd_addr[P_EX1] = rd1_addr;

  assign rhs      = in_use_imm ? in_imm : rd_data[P_RHS];
  assign rd0_data = rd_data[P_EX0];
  assign rd1_data = rd_data[P_EX1];

  exec_regbank #(
    .DATA_W   (DATA_W),
    .REG_CNT  (REG_CNT),
    .RD_PORTS (RD_PORTS)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take && legal),
    .wr_addr (in_dst),
    .wr_data (result),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  exec_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op        (in_op),
    .lhs       (rd_data[P_LHS]),
    .rhs       (rhs),
    .result    (result),
    .carry_out (carry_out),
    .carry_upd (carry_upd),
    .legal     (legal)
  );

  exec_flags #(
    .DATA_W (DATA_W)
  ) u_flags (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .legal     (legal),
    .result    (result),
    .carry_upd (carry_upd),
    .carry_in  (carry_out),
    .zero_q    (flag_zero),
    .carry_q   (flag_carry),
    .err_q     (op_error)
  );

endmodule

// File: rtl/exec_regfile_alu_chk.sv
module exec_regfile_alu_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  in_op,
  input logic        flag_zero,
  input logic        flag_carry,
  input logic        op_error,
  input logic [2:0]  rd0_addr,
  input logic [15:0] rd0_data,
  input logic [2:0]  rd1_addr,
  input logic [15:0] rd1_data
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  low_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_addr == 3'd0) |-> (rd0_data == 16'h0000));

  // R3
  high_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd1_addr == 3'd7) |-> (rd1_data == 16'hFFFF));

  // R11
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op[3]) |=> op_error);

  // R11
  err_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op[3]) |=> ($stable(flag_zero) && $stable(flag_carry)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> (!op_error && $stable(flag_zero) && $stable(flag_carry)));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_op[3] && in_op > 4'd1) |=> $stable(flag_carry));

  // R12
  ready_chk: assert property (@(posedge clk) !rst |-> in_ready);

endmodule

bind exec_regfile_alu exec_regfile_alu_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .flag_zero  (flag_zero),
  .flag_carry (flag_carry),
  .op_error   (op_error),
  .rd0_addr   (rd0_addr),
  .rd0_data   (rd0_data),
  .rd1_addr   (rd1_addr),
  .rd1_data   (rd1_data)
);

// File: tb/exec_regfile_alu_test.sv
`timescale 1ns/1ps
module exec_regfile_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_use_imm = 1'b0;
  logic [2:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [15:0] in_imm = '0;
  logic        flag_zero, flag_carry, op_error;
  logic [2:0]  rd0_addr = '0, rd1_addr = '0;
  logic [15:0] rd0_data, rd1_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_reg [8];
  logic        m_z, m_c, m_err;

  always #5 clk = ~clk;

  exec_regfile_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_use_imm(in_use_imm), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_imm(in_imm),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .op_error(op_error),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic model_apply(input logic v, input logic [3:0] op, input logic im,
                             input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
                             input logic [15:0] imm);
    logic [15:0] l, r, res;
    logic [16:0] wide;
    l = m_reg[a];
    r = im ? imm : m_reg[b];
    m_err = v && (op >= 4'd8);
    if (!v || op >= 4'd8) return;
    res = '0;
    case (op)
      4'd0: begin wide = {1'b0, l} + {1'b0, r}; res = wide[15:0]; m_c = wide[16]; end
      4'd1: begin res = l - r; m_c = (l < r); end
      4'd2: res = (r >= 16) ? 16'h0 : 16'(l << r);
      4'd3: res = (r >= 16) ? 16'h0 : 16'(l >> r);
      4'd4: res = l & r;
      4'd5: res = l | r;
      4'd6: res = l ^ r;
      default: res = 16'(32'(l) * 32'(r));
    endcase
    m_z = (res == 16'h0);
    if (d != 3'd0 && d != 3'd7) m_reg[d] = res;
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic im,
                      input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
                      input logic [15:0] imm, input logic [2:0] p0, input logic [2:0] p1,
                      input string tag);
    in_valid = v; in_op = op; in_use_imm = im; in_dst = d;
    in_src_a = a; in_src_b = b; in_imm = imm;
    @(posedge clk);
    model_apply(v, op, im, d, a, b, imm);
    @(negedge clk);
    rd0_addr = p0; rd1_addr = p1;
    #1;
    check("R6 zero flag", 16'(flag_zero), 16'(m_z));
    check("R9 carry flag", 16'(flag_carry), 16'(m_c));
    check("R11 op_error", 16'(op_error), 16'(m_err));
    check({tag, " rd0"}, rd0_data, m_reg[p0]);
    check({tag, " rd1"}, rd1_data, m_reg[p1]);
    check("R12 in_ready", 16'(in_ready), 16'h1);
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = (i == 7) ? 16'hFFFF : 16'h0;
    m_z = 0; m_c = 0; m_err = 0;
    repeat (3) @(negedge clk);
    check("R12 ready low in reset", 16'(in_ready), 16'h0);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R1 R2 R3
    for (int i = 0; i < 8; i++) begin
      rd0_addr = 3'(i); rd1_addr = 3'(i); #1;
      check("R1 R2 R3 reset rd0", rd0_data, m_reg[i]);
      check("R1 R2 R3 reset rd1", rd1_data, m_reg[i]);
    end
    check("R6 reset zero", 16'(flag_zero), 16'h0);
    check("R11 reset err", 16'(op_error), 16'h0);

    // loop program: r1=2, r2=20, r3=0, repeat r3+=r1, r2-=1 (R7, R1)
    step(1, 4'd5, 1, 3'd1, 3'd0, 3'd0, 16'd2,  3'd1, 3'd0, "R7 or-imm");
    step(1, 4'd5, 1, 3'd2, 3'd0, 3'd0, 16'd20, 3'd2, 3'd1, "R7 or-imm");
    step(1, 4'd5, 1, 3'd3, 3'd0, 3'd0, 16'd0,  3'd3, 3'd2, "R7 or-imm");
    for (int k = 0; k < 20; k++) begin
      step(1, 4'd0, 0, 3'd3, 3'd3, 3'd1, 16'd0, 3'd3, 3'd1, "R1 add");
      step(1, 4'd1, 1, 3'd2, 3'd2, 3'd0, 16'd1, 3'd2, 3'd3, "R1 sub-imm");
    end
    check("R1 loop total", rd1_data, 16'h0028);

    // carry and borrow, wrap (R8 R9)
    step(1, 4'd0, 1, 3'd4, 3'd7, 3'd0, 16'd1, 3'd4, 3'd7, "R8 add wrap");
    step(1, 4'd1, 1, 3'd5, 3'd0, 3'd0, 16'd1, 3'd5, 3'd0, "R8 sub wrap");
    step(1, 4'd4, 1, 3'd6, 3'd7, 3'd0, 16'h00F0, 3'd6, 3'd0, "R9 carry holds");
    step(1, 4'd7, 1, 3'd6, 3'd5, 3'd0, 16'h0003, 3'd6, 3'd5, "R5 R8 mul wrap");
    // shifts (R8 R10)
    step(1, 4'd3, 1, 3'd1, 3'd7, 3'd0, 16'd15, 3'd1, 3'd7, "R8 shr logical");
    step(1, 4'd2, 1, 3'd1, 3'd7, 3'd0, 16'd15, 3'd1, 3'd0, "R5 shl 15");
    step(1, 4'd2, 1, 3'd1, 3'd7, 3'd0, 16'd16, 3'd1, 3'd0, "R10 shl 16");
    step(1, 4'd3, 1, 3'd1, 3'd7, 3'd0, 16'd20, 3'd1, 3'd0, "R10 shr 20");
    step(1, 4'd5, 1, 3'd2, 3'd0, 3'd0, 16'd17, 3'd2, 3'd0, "R7 set shift");
    step(1, 4'd3, 0, 3'd1, 3'd7, 3'd2, 16'd0, 3'd1, 3'd2, "R10 shr by reg");
    // writes to constants (R4)
    step(1, 4'd6, 1, 3'd0, 3'd7, 3'd0, 16'h1234, 3'd0, 3'd7, "R4 write r0");
    step(1, 4'd6, 0, 3'd7, 3'd7, 3'd7, 16'h0, 3'd7, 3'd0, "R4 write r7 zero");
    step(1, 4'd0, 0, 3'd7, 3'd7, 3'd7, 16'h0, 3'd7, 3'd0, "R4 write r7 carry");
    // illegal codes (R11) and idle cycles (R12)
    step(1, 4'd9, 1, 3'd3, 3'd0, 3'd0, 16'h5, 3'd3, 3'd1, "R11 illegal");
    step(1, 4'd15, 1, 3'd3, 3'd0, 3'd0, 16'h5, 3'd3, 3'd1, "R11 illegal again");
    step(0, 4'd0, 1, 3'd3, 3'd0, 3'd0, 16'h5, 3'd3, 3'd1, "R12 idle");

    // random mix, compared every clock
    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      op = ($urandom % 10 < 8) ? 4'($urandom % 8) : 4'(8 + $urandom % 8);
      step(($urandom % 8) != 0, op, 1'($urandom), 3'($urandom), 3'($urandom),
           3'($urandom), (($urandom % 4) == 0) ? 16'($urandom % 20) : 16'($urandom),
           3'($urandom), 3'($urandom), "R1 R5 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule